// File: doc/BRIEF.md
# Device Power-State Sequencing Controller

This controller moves a processor-based device between bus-style device power states. The states are an uninitialised D0, an active D0, three light sleep states (D1, D2 and D3hot, which map to the core's doze, nap and sleep modes), a warm deep state (D3warm) and a cold off state (D3cold). Software requests a target through a two-bit request field and a power-off bit. The controller then drives the core mode code and the enables for two supply domains: a switchable rail and an always-on core rail. The switchable rail is turned off before D3warm is entered. When D3warm is left, the rail is turned on again and then qualified by a settle count and a power-good input.

Six wake sources, each with its own mask bit, are combined into one wake condition. In host mode a masked wake brings the device straight out of D3warm. In agent mode a masked wake only raises a power-management event line toward the host. The device then stays in D3warm until the host writes power state 00. Every exit from D3warm lands in the uninitialised D0, so software must signal again that initialisation is complete.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, the state code is 0 (D0 uninitialised). Both supply enables are 1, pme is 0, the request field reads 00 and core_mode is 00.
- R2: From state 0 the controller moves to state 1 (D0 active) only in the cycle after init_done is high. Request-field values written while in state 0 cause no other transition.
- R3: In state 1 the request field is decoded as follows:
  - 01 leads to state 8 (D3cold).
  - 10 with the power-off bit set leads to state 5 (supply-down step) and then to state 6 (D3warm).
  - 10 with the power-off bit clear keeps state 1.
  - 11 leads to a light state chosen by lp_sel: 00 gives state 2 (D1), 01 gives state 3 (D2), and 10 or 11 gives state 4 (D3hot).
- R4: A wake hit exists when (wake_evt & wake_msk) is nonzero. The bit positions are 0 USB, 1 Ethernet, 2 GPIO, 3 PCI, 4 interrupt and 5 timer. An event whose mask bit is 0 has no effect.
- R5: The light states drive core_mode 01 (state 2), 10 (state 3) and 11 (state 4). Each returns to state 1 on tb_wake, core_irq or a wake hit, and the request field is cleared to 00 on that return.
- R6: In host mode (pme_en = 0), state 6 moves to state 7 (supply-up) on any of: a wake hit, core_irq, bus_act, or a software write of 00 to the request field. The request field is cleared on that exit, and pme stays 0.
- R7: In agent mode (pme_en = 1), a wake hit in state 6 sets pme without leaving the state. A host write (host_ps_wr) of host_ps = 00 moves the controller to state 7 and clears the request field. pme falls at the same clock edge as that move. A host write of any other value is ignored.
- R8: vdd_en is 0 in states 5 and 6 while vddc_en stays 1. vdd_en is 1 in state 7.
- R9: State 7 moves to state 0 only after settle_dly+1 cycles in state 7, and only once vdd_pg is high. It waits as long as vdd_pg is low.
- R10: In state 8 both supply enables are 0, and the controller stays there until reset whatever its inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| init_done | input | 1 | Software signals that initialisation is complete |
| cfg_wr | input | 1 | Write strobe for the request field and power-off bit |
| cfg_next | input | 2 | Request field value to write |
| cfg_off | input | 1 | Power-off bit value to write |
| lp_sel | input | 2 | Selects which light state a request of 11 enters |
| pme_en | input | 1 | 1 selects agent mode, 0 selects host mode |
| wake_evt | input | NSRC | Wake event bits |
| wake_msk | input | NSRC | Wake mask bits |
| tb_wake | input | 1 | Time-base wake request from the core |
| core_irq | input | 1 | Core interrupt request |
| bus_act | input | 1 | Bus activity seen |
| host_ps_wr | input | 1 | Host write strobe for the power state |
| host_ps | input | 2 | Power state value written by the host |
| vdd_pg | input | 1 | Power-good of the switchable rail |
| settle_dly | input | CNT_W | Settle count for rail power-up |
| state | output | 4 | Current state code |
| core_mode | output | 2 | Core mode: 00 run, 01 doze, 10 nap, 11 sleep |
| nxt_field | output | 2 | Current request field |
| vdd_en | output | 1 | Enable for the switchable rail |
| vddc_en | output | 1 | Enable for the core rail |
| pme | output | 1 | Power-management event line toward the host |

## Verification
The hardest situation to reach is the agent-mode handshake. The controller must already be in D3warm with pme raised by an earlier masked wake. The bench then sends a non-zero host write, which must be ignored, before the final write of 00. pme must fall on the same edge on which the state leaves. The bench reaches this point by running the full entry sequence (request write, supply-down step, warm state) in agent mode. It then repeats the power-up qualification for several settle counts, with power-good first held low and then raised, so that the length of the supply-up state can be checked arithmetically.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int NSRC  = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_done,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_next,
  input  logic             cfg_off,
  input  logic [1:0]       lp_sel,
  input  logic             pme_en,
  input  logic [NSRC-1:0]  wake_evt,
  input  logic [NSRC-1:0]  wake_msk,
  input  logic             tb_wake,
  input  logic             core_irq,
  input  logic             bus_act,
  input  logic             host_ps_wr,
  input  logic [1:0]       host_ps,
  input  logic             vdd_pg,
  input  logic [CNT_W-1:0] settle_dly,
  output logic [3:0]       state,
  output logic [1:0]       core_mode,
  output logic [1:0]       nxt_field,
  output logic             vdd_en,
  output logic             vddc_en,
  output logic             pme
);

  typedef enum logic [3:0] {
    S_UNINIT = 4'd0,
    S_ACT    = 4'd1,
    S_D1     = 4'd2,
    S_D2     = 4'd3,
    S_D3H    = 4'd4,
    S_WDN    = 4'd5,
    S_WARM   = 4'd6,
    S_WUP    = 4'd7,
    S_COLD   = 4'd8
  } st_t;

  st_t              st, st_n;
  logic [1:0]       nxt_q;
  logic             off_q;
  logic             pme_q;
  logic             clr_nxt;
  logic [CNT_W-1:0] cnt;

  wire wake_hit = |(wake_evt & wake_msk);
  wire cnt_done = (cnt == settle_dly);
  wire host_d0  = pme_en & host_ps_wr & (host_ps == 2'b00);
  wire warm_go  = core_irq | bus_act | (nxt_q == 2'b00) |
                  (~pme_en & wake_hit) | host_d0;
  wire lite_go  = tb_wake | core_irq | wake_hit;

  always_comb begin
    st_n    = st;
    clr_nxt = 1'b0;
    case (st)
      S_UNINIT: if (init_done) st_n = S_ACT;
      S_ACT: begin
        case (nxt_q)
          2'b01: st_n = S_COLD;
          2'b10: if (off_q) st_n = S_WDN;
          2'b11: begin
            case (lp_sel)
              2'b00:   st_n = S_D1;
              2'b01:   st_n = S_D2;
              default: st_n = S_D3H;
            endcase
          end
          default: ;
        endcase
      end
      S_D1, S_D2, S_D3H: if (lite_go) begin
        st_n    = S_ACT;
        clr_nxt = 1'b1;
      end
      S_WDN:  st_n = S_WARM;
      S_WARM: if (warm_go) begin
        st_n    = S_WUP;
        clr_nxt = 1'b1;
      end
      S_WUP:  if (cnt_done && vdd_pg) st_n = S_UNINIT;
      S_COLD: ;
      default: st_n = S_UNINIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_UNINIT;
      nxt_q <= 2'b00;
      off_q <= 1'b0;
      pme_q <= 1'b0;
      cnt   <= '0;
    end else begin
      st <= st_n;
      if (clr_nxt) nxt_q <= 2'b00;
      else if (cfg_wr) begin
        nxt_q <= cfg_next;
        off_q <= cfg_off;
      end
      pme_q <= (st == S_WARM) && (st_n == S_WARM) && (pme_q || (pme_en && wake_hit));
      if (st != S_WUP) cnt <= '0;
      else if (!cnt_done) cnt <= cnt + 1'b1;
    end
  end

  assign state     = st;
  assign nxt_field = nxt_q;
  assign pme       = pme_q;
  assign vdd_en    = !(st == S_WDN || st == S_WARM || st == S_COLD);
  assign vddc_en   = (st != S_COLD);
  assign core_mode = (st == S_D1)  ? 2'b01 :
                     (st == S_D2)  ? 2'b10 :
                     (st == S_D3H) ? 2'b11 : 2'b00;

  AST_INIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd0 && !init_done) |=> state == 4'd0); // R2

  AST_WARM_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd5 || state == 4'd6) |-> (!vdd_en && vddc_en)); // R8

  AST_COLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd8 |=> (state == 4'd8 && !vdd_en && !vddc_en)); // R10

  AST_PME_WARM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pme |-> state == 4'd6); // R7

  AST_PME_HOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pme_en |=> !pme || $past(pme_en)); // R6

  AST_UP_NEEDS_PG: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd7 && !vdd_pg) |=> state == 4'd7); // R9

  AST_WDN_TO_WARM: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd5 |=> state == 4'd6); // R3

  AST_LITE_EXIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == 4'd2 || state == 4'd3 || state == 4'd4) && (tb_wake || core_irq)) |=>
    (state == 4'd1 && nxt_field == 2'b00)); // R5

endmodule

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  localparam int NSRC = 6;
  localparam int CW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_done = 0, cfg_wr = 0, cfg_off = 0, pme_en = 0;
  logic [1:0] cfg_next = 0, lp_sel = 0, host_ps = 0;
  logic [NSRC-1:0] wake_evt = 0, wake_msk = 0;
  logic tb_wake = 0, core_irq = 0, bus_act = 0, host_ps_wr = 0, vdd_pg = 1;
  logic [CW-1:0] settle_dly = 0;
  logic [3:0] state;
  logic [1:0] core_mode, nxt_field;
  logic vdd_en, vddc_en, pme;

  int ntot = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl #(.NSRC(NSRC), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .cfg_wr(cfg_wr),
    .cfg_next(cfg_next), .cfg_off(cfg_off), .lp_sel(lp_sel), .pme_en(pme_en),
    .wake_evt(wake_evt), .wake_msk(wake_msk), .tb_wake(tb_wake),
    .core_irq(core_irq), .bus_act(bus_act), .host_ps_wr(host_ps_wr),
    .host_ps(host_ps), .vdd_pg(vdd_pg), .settle_dly(settle_dly),
    .state(state), .core_mode(core_mode), .nxt_field(nxt_field),
    .vdd_en(vdd_en), .vddc_en(vddc_en), .pme(pme));

  task automatic chk(string req, int act, int exp);
    ntot++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_next(logic [1:0] v, logic off);
    cfg_wr = 1; cfg_next = v; cfg_off = off;
    step();
    cfg_wr = 0;
  endtask

  task automatic do_init();
    init_done = 1; step(); init_done = 0;
    chk("R2 init to active", state, 1);
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1; step();
  endtask

  task automatic enter_warm();
    wr_next(2'b10, 1'b1);
    step();
    chk("R3 down step", state, 5);
    chk("R8 vdd off in down step", vdd_en, 0);
    chk("R8 vddc on in down step", vddc_en, 1);
    step();
    chk("R3 warm", state, 6);
    chk("R8 vdd off in warm", vdd_en, 0);
  endtask

  task automatic power_up(int s, int lowc);
    chk("R8 vdd on in up", vdd_en, 1);
    for (int k = 0; k < s; k++) begin
      step(); chk("R9 settle wait", state, 7);
    end
    if (lowc > 0) begin
      vdd_pg = 0;
      for (int k = 0; k < lowc; k++) begin
        step(); chk("R9 pg low wait", state, 7);
      end
      vdd_pg = 1;
    end
    step();
    chk("R9 up to uninit", state, 0);
    do_init();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      ntot++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 state", state, 0);
    chk("R1 vdd_en", vdd_en, 1);
    chk("R1 vddc_en", vddc_en, 1);
    chk("R1 pme", pme, 0);
    chk("R1 field", nxt_field, 0);
    chk("R1 core_mode", core_mode, 0);

    wr_next(2'b01, 1'b0);
    for (int k = 0; k < 4; k++) begin
      step(); chk("R2 hold uninit", state, 0);
    end
    wr_next(2'b00, 1'b0);
    step();
    do_init();

    wr_next(2'b10, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(); chk("R3 10 without off", state, 1);
    end
    wr_next(2'b00, 1'b0);

    for (int lp = 0; lp < 4; lp++) begin
      for (int e = 0; e < 64; e++) begin
        for (int mi = 0; mi < 4; mi++) begin
          logic [5:0] m;
          int ls;
          bit hit;
          m = (mi == 0) ? 6'h3F : (mi == 1) ? 6'h15 : (mi == 2) ? 6'h2A : 6'h00;
          ls = (lp == 0) ? 2 : (lp == 1) ? 3 : 4;
          hit = ((e[5:0] & m) != 0);
          lp_sel = lp[1:0];
          wr_next(2'b11, 1'b0);
          step();
          chk("R3 light entry", state, ls);
          chk("R5 core mode", core_mode, ls - 1);
          wake_evt = e[5:0]; wake_msk = m;
          step();
          wake_evt = 0; wake_msk = 0;
          chk("R4 masked wake", state, hit ? 1 : ls);
          chk("R5 field clear", nxt_field, hit ? 0 : 3);
          if (!hit) begin
            if (mi[0]) core_irq = 1; else tb_wake = 1;
            step();
            core_irq = 0; tb_wake = 0;
            chk("R5 tb/irq wake", state, 1);
            chk("R5 field clear irq", nxt_field, 0);
          end
        end
      end
    end

    pme_en = 0;
    for (int src = 0; src < 9; src++) begin
      enter_warm();
      wake_evt = 6'h3F; wake_msk = 6'h00;
      step();
      chk("R4 unmasked ignored in warm", state, 6);
      wake_evt = 0;
      if (src < 6) begin
        wake_evt = 6'(1 << src); wake_msk = 6'(1 << src);
        step();
      end else if (src == 6) begin
        core_irq = 1; step();
      end else if (src == 7) begin
        bus_act = 1; step();
      end else begin
        wr_next(2'b00, 1'b0);
        step();
      end
      wake_evt = 0; wake_msk = 0; core_irq = 0; bus_act = 0;
      chk("R6 host warm exit", state, 7);
      chk("R6 field cleared", nxt_field, 0);
      chk("R6 pme quiet", pme, 0);
      settle_dly = 8'(src % 3);
      power_up(src % 3, src % 2);
    end

    pme_en = 1;
    for (int s = 0; s < 5; s++) begin
      enter_warm();
      wake_evt = 6'h10; wake_msk = 6'h10;
      step();
      wake_evt = 0; wake_msk = 0;
      chk("R7 agent stays warm", state, 6);
      chk("R7 pme set", pme, 1);
      step(); step();
      chk("R7 pme held", pme, 1);
      host_ps_wr = 1; host_ps = 2'(1 + (s % 3));
      step();
      host_ps_wr = 0;
      chk("R7 nonzero host write ignored", state, 6);
      chk("R7 pme still held", pme, 1);
      chk("R7 field kept", nxt_field, 2);
      host_ps_wr = 1; host_ps = 2'b00;
      step();
      host_ps_wr = 0;
      chk("R7 host D0 exit", state, 7);
      chk("R7 pme falls on exit", pme, 0);
      chk("R7 field cleared", nxt_field, 0);
      settle_dly = 8'(s);
      power_up(s, (s == 2) ? 3 : 0);
    end
    pme_en = 0;

    wr_next(2'b01, 1'b0);
    step();
    chk("R3 cold entry", state, 8);
    chk("R10 vdd off", vdd_en, 0);
    chk("R10 vddc off", vddc_en, 0);
    core_irq = 1; bus_act = 1; tb_wake = 1; init_done = 1;
    wake_evt = 6'h3F; wake_msk = 6'h3F;
    wr_next(2'b00, 1'b0);
    for (int k = 0; k < 4; k++) begin
      step(); chk("R10 cold sticky", state, 8);
    end
    core_irq = 0; bus_act = 0; tb_wake = 0; init_done = 0;
    wake_evt = 0; wake_msk = 0;
    do_reset();
    chk("R1 state after reset from cold", state, 0);
    chk("R1 rails after reset from cold", {vdd_en, vddc_en}, 3);

    done = 1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule